// File: doc/BRIEF.md
# Interleaved Section Result Merger

This block sits behind eight time-interleaved successive-approximation converter sections. Each section samples the analog input in turn, on every other clock edge, and holds an 11-bit result. The merger picks the result of one section at a time with an 8:1 selector and walks the sections in the same round-robin order in which they sampled. It rounds each result to a 10-bit straight-binary word and registers the word on the rising clock edge. With each word it raises a data-available strobe for one clock.

Time is counted in rising edges. Edge 0 is the first rising edge at which `rst_n` is sampled high. Section `n mod 8` samples at edge `2n`. The word for a sample taken at edge E is captured at edge E+12 from the selected section's result bus, so the section must present its result before that edge. A new word follows every two clocks.

The output enable is active low. It works without the clock: when it is high the tri-state bus floats and `drive_o` is low. `word_o` always carries the registered word, whatever the enable does.

The sequencer has three states:
- `ST_WARM` is entered on reset and counts edges 0 to 11. At edge 11 it moves to `ST_LOAD`.
- `ST_LOAD` captures a word, advances the section select and raises the strobe. At the next edge it moves to `ST_HOLD`.
- `ST_HOLD` drops the strobe and holds the word. At the next edge it returns to `ST_LOAD`.

Top module: `adc_merge`

## Requirements
- R1: While `rst_n` is low, `dav_o` = 0 and `word_o` = 0. After reset, `dav_o` stays low through edges 0 to 11.
- R2: `dav_o` first rises after edge 12. After that, `dav_o` is high after every even edge and low after every odd edge.
- R3: `dav_o` never stays high for two consecutive clocks.
- R4: Words are taken from sections in the order 0,1,...,7,0,... and the select wraps from 7 to 0.
- R5: The word captured at edge E+12 comes from the section that sampled at edge E. `sec_res_i[s*11 +: 11]` is section s's result, and the word uses the value present at edge E+12.
- R6: Each 11-bit result r is reduced to `floor((r+1)/2)`, which is round-half-up of r/2.
- R7: A result whose reduced value would be 1024 (r = 2047) saturates to 1023.
- R8: `word_o` changes only at edges where `dav_o` rises. It holds its value between those edges.
- R9: With `oe_n_i` = 0, `drive_o` = 1 and `bus_o` equals `word_o`. With `oe_n_i` = 1, `drive_o` = 0 and `bus_o` is high impedance. Both follow `oe_n_i` without waiting for a clock edge.
- R10: `oe_n_i` has no effect on `word_o` or `dav_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, twice the sample rate |
| rst_n | input | 1 | Synchronous active-low reset |
| sec_res_i | input | 88 | Eight 11-bit section results; section s occupies bits s*11 +: 11 |
| oe_n_i | input | 1 | Active-low output enable |
| word_o | output | 10 | Registered 10-bit straight-binary word, always driven |
| dav_o | output | 1 | One-clock data-available strobe |
| drive_o | output | 1 | High when the tri-state bus is driven |
| bus_o | output | 10 | Tri-state copy of `word_o` |

## Verification
The bench writes each section's result four edges after that section samples and keeps it until the section's next slot. A design that captures at the wrong edge therefore picks up the previous round's value, and one with a wrong select start or wrap mixes sections up; both show as word mismatches. The first pattern values are 0, 1, 2, 3, 1023, 1024, 2046 and 2047. Plain truncation gets 1, 3 and 1023 wrong, and a rounder without saturation wraps 2047 to zero. The enable is toggled both mid-cycle and over long windows. This exposes an enable that is registered instead of immediate, or one that gates the strobe or the stored word.

// File: rtl/adc_merge_pkg.sv
package adc_merge_pkg;

    // Sequencer states of the merger.
    typedef enum logic [1:0] {
        ST_WARM = 2'd0,
        ST_LOAD = 2'd1,
        ST_HOLD = 2'd2
    } mrg_state_e;

endpackage

// File: rtl/mrg_seq.sv
module mrg_seq
    import adc_merge_pkg::*;
#(
    parameter int NSEC = 8,
    parameter int LAT  = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    output logic                    ld_o,
    output logic [$clog2(NSEC)-1:0] sel_o
);
    localparam int SELW = $clog2(NSEC);
    localparam int CW   = $clog2(LAT);

    mrg_state_e      state_q, state_d;
    logic [CW-1:0]   wcnt_q;
    logic [SELW-1:0] sel_q;

    // State register and counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_WARM;
            wcnt_q  <= '0;
            sel_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_WARM) begin
                wcnt_q <= wcnt_q + 1'b1;
            end
            if (ld_o) begin
                sel_q <= (sel_q == SELW'(NSEC - 1)) ? '0 : sel_q + 1'b1;
            end
        end
    end

    // Next state and outputs.
    always_comb begin
        state_d = state_q;
        ld_o    = 1'b0;
        unique case (state_q)
            ST_WARM: begin
                if (wcnt_q == CW'(LAT - 1)) begin
                    state_d = ST_LOAD;
                end
            end
            ST_LOAD: begin
                ld_o    = 1'b1;
                state_d = ST_HOLD;
            end
            ST_HOLD: begin
                state_d = ST_LOAD;
            end
            default: begin
                state_d = ST_WARM;
            end
        endcase
    end

    assign sel_o = sel_q;

    // R2
    ld_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_o |=> !ld_o);

    // R4
    sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_o |=> $stable(sel_o));

endmodule

// File: rtl/mrg_pick.sv
module mrg_pick #(
    parameter int NSEC = 8,
    parameter int RW   = 11,
    parameter int OW   = 10
) (
    input  logic [NSEC*RW-1:0]      sec_flat_i,
    input  logic [$clog2(NSEC)-1:0] sel_i,
    output logic [OW-1:0]           word_o
);
    localparam int DROP = RW - OW;

    logic [RW-1:0] res;

    assign res = sec_flat_i[sel_i*RW +: RW];

    generate
        if (DROP == 0) begin : g_pass
            assign word_o = res;
        end else begin : g_round
            logic [RW:0] sum;
            logic [OW:0] q;
            assign sum    = {1'b0, res} + ((RW + 1)'(1) << (DROP - 1));
            assign q      = (OW + 1)'(sum >> DROP);
            assign word_o = q[OW] ? '1 : q[OW-1:0];
        end
    endgenerate

    // R7
    always_comb begin
        if (res == '1) begin
            sat_top_chk: assert (word_o == '1);
        end
    end

endmodule

// File: rtl/mrg_out.sv
module mrg_out #(
    parameter int OW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_i,
    input  logic [OW-1:0] word_i,
    input  logic          oe_n_i,
    output logic [OW-1:0] word_o,
    output logic          dav_o,
    output logic          drive_o,
    output logic [OW-1:0] bus_o
);
    logic [OW-1:0] word_q;
    logic          dav_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
            dav_q  <= 1'b0;
        end else begin
            dav_q <= ld_i;
            if (ld_i) begin
                word_q <= word_i;
            end
        end
    end

    assign word_o  = word_q;
    assign dav_o   = dav_q;
    assign drive_o = ~oe_n_i;
    assign bus_o   = oe_n_i ? 'z : word_q;

    // R3
    dav_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dav_o |=> !dav_o);

    // R8
    word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_i |=> $stable(word_o));

    // R9
    bus_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n_i |-> (bus_o == word_o));

endmodule

// File: rtl/adc_merge.sv
module adc_merge #(
    parameter int NSEC = 8,
    parameter int RW   = 11,
    parameter int OW   = 10,
    parameter int LAT  = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NSEC*RW-1:0] sec_res_i,
    input  logic               oe_n_i,
    output logic [OW-1:0]      word_o,
    output logic               dav_o,
    output logic               drive_o,
    output logic [OW-1:0]      bus_o
);
    localparam int SELW = $clog2(NSEC);

    logic            ld;
    logic [SELW-1:0] sel;
    logic [OW-1:0]   picked;

    mrg_seq #(.NSEC(NSEC), .LAT(LAT)) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .ld_o  (ld),
        .sel_o (sel)
    );

    mrg_pick #(.NSEC(NSEC), .RW(RW), .OW(OW)) u_pick (
        .sec_flat_i (sec_res_i),
        .sel_i      (sel),
        .word_o     (picked)
    );

    mrg_out #(.OW(OW)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_i    (ld),
        .word_i  (picked),
        .oe_n_i  (oe_n_i),
        .word_o  (word_o),
        .dav_o   (dav_o),
        .drive_o (drive_o),
        .bus_o   (bus_o)
    );

endmodule

// File: tb/adc_merge_tb_top.sv
`timescale 1ns/1ps
module adc_merge_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [87:0] sec = '0;
    logic        oe_n = 1'b0;
    logic [9:0]  word_o;
    logic        dav_o;
    logic        drive_o;
    logic [9:0]  bus_o;

    int n_tests = 0;
    int n_fail  = 0;
    int q_time[$];
    int q_val[$];
    int last_word = 0;

    always #2.5 clk = ~clk;

    adc_merge dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .sec_res_i (sec),
        .oe_n_i    (oe_n),
        .word_o    (word_o),
        .dav_o     (dav_o),
        .drive_o   (drive_o),
        .bus_o     (bus_o)
    );

    task automatic check(input string tag, input bit ok, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int pattern(input int n);
        case (n)
            0: return 0;
            1: return 2047;
            2: return 1;
            3: return 2046;
            4: return 1024;
            5: return 1023;
            6: return 3;
            7: return 2;
            default: return int'($urandom_range(0, 2047));
        endcase
    endfunction

    function automatic int reduce(input int r);
        int e;
        e = (r + 1) / 2;
        if (e > 1023) e = 1023;
        return e;
    endfunction

    task automatic check_bus(input string tag);
        check({tag, " R9 drive"}, drive_o == !oe_n, int'(drive_o), int'(!oe_n));
        if (!oe_n) begin
            check({tag, " R9 bus"}, bus_o == 10'(last_word), int'(bus_o), last_word);
        end
    endtask

    initial begin : watchdog
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        // R1 reset state
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R1 reset dav", dav_o == 1'b0, int'(dav_o), 0);
            check("R1 reset word", word_o == 10'd0, int'(word_o), 0);
        end
        rst_n = 1'b1;
        for (int k = 0; k < 400; k++) begin
            bit exp_dav;
            int exp_sat;
            @(posedge clk);
            @(negedge clk);
            exp_dav = (q_time.size() > 0) && (q_time[0] == k);
            exp_sat = 0;
            if (exp_dav) begin
                void'(q_time.pop_front());
                last_word = q_val.pop_front();
                exp_sat = (last_word == 1023) ? 1 : 0;
            end
            if (k < 12) begin
                check("R1 warm dav", dav_o == 1'b0, int'(dav_o), 0);
            end else begin
                check("R2 R3 dav", dav_o == exp_dav, int'(dav_o), int'(exp_dav));
            end
            if (exp_dav) begin
                check(exp_sat != 0 ? "R4 R5 R7 word" : "R4 R5 R6 word",
                      word_o == 10'(last_word), int'(word_o), last_word);
            end else begin
                check("R8 R10 hold", word_o == 10'(last_word), int'(word_o), last_word);
            end
            check_bus("edge");
            // section results: written four edges after the sample edge
            if (k >= 4 && ((k - 4) % 2) == 0) begin
                int n;
                int v;
                n = (k - 4) / 2;
                v = pattern(n);
                sec[(n % 8) * 11 +: 11] = 11'(v);
                q_time.push_back(k + 8);
                q_val.push_back(reduce(v));
            end
            // enable pattern: long window plus isolated toggles
            oe_n = ((k >= 100) && (k < 140)) || ((k % 37) == 5);
            #1;
            check_bus("async");
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule